// File: doc/BRIEF.md
# Phase Comparison Coincidence Integrator

This block makes the trip decision for a phase comparison line protection scheme. Once per sample it receives already aligned pulse flags: a fault detector flag, and for each polarity a local pulse and up to two received remote pulses. From these it forms a coincidence condition. In two-terminal operation the condition uses one remote pulse; in three-terminal operation it uses both.

Each coincidence condition drives a saturating up/down integrator. A coincident sample adds a fixed step. A sample without coincidence subtracts a small step while the dropout is short, and a large step once the dropout has lasted longer than a programmable number of samples. This brings a real fault to a trip even when the pulses chatter, and it empties the integrator quickly once the coincidence ends.

A registered trip flag rises when a running integrator reaches the programmable setting. In single-comparison mode only the positive path runs. In dual-comparison mode the positive and negative paths run independently, and either one can trip. The sample strobe works as a valid signal that cannot be refused: every strobed sample is taken in the same clock, so the block never applies back-pressure and has no ready output. Threshold, ceiling, dropout length and modes are plain control pins.

Top module: `pc_coinc_integ`

## Requirements
- R1: With `three_term`=0, the coincidence of a polarity is `fault_det` AND local pulse AND remote-1 pulse. The remote-2 pulse has no effect.
- R2: With `three_term`=1, the coincidence also needs the remote-2 pulse. A sample in which only remote-2 is low counts as no coincidence.
- R3: A strobed sample with coincidence raises the integrator by 10. The result is clamped at `int_max`, and the integrator never wraps.
- R4: Strobed samples without coincidence lower the integrator by 5, as long as the number of zero samples in the run is no more than `ext_len`.
- R5: Each further zero sample in the same run lowers the integrator by 20. The integrator stops at 0.
- R6: A coincident sample restarts the dropout run. The next zero sample again lowers the integrator by 5.
- R7: Integrators, dropout runs and the trip flag change only in a clock in which `smp_en` is 1.
- R8: In the clock after a strobe, `trip` is 1 exactly when the positive integrator, or in dual mode the negative integrator, is at or above `thresh`.
- R9: With `dual_mode`=0, the negative integrator is held at 0 and the negative pulses are ignored.
- R10: With `dual_mode`=1, the negative path integrates its own coincidence independently of the positive path.
- R11: A synchronous `rst` clears both integrators, both dropout runs and `trip`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe (valid; always accepted) |
| dual_mode | input | 1 | 1 = both polarities, 0 = positive only |
| three_term | input | 1 | 1 = two remote pulses required |
| fault_det | input | 1 | Fault detector flag |
| loc_pos | input | 1 | Local positive pulse |
| rem1_pos | input | 1 | Remote-1 positive pulse |
| rem2_pos | input | 1 | Remote-2 positive pulse |
| loc_neg | input | 1 | Local negative pulse |
| rem1_neg | input | 1 | Remote-1 negative pulse |
| rem2_neg | input | 1 | Remote-2 negative pulse |
| thresh | input | 16 | Trip setting |
| int_max | input | 16 | Integrator ceiling |
| ext_len | input | 8 | Zero samples taken at the small down step |
| trip | output | 1 | Registered trip flag |
| int_pos | output | 16 | Positive integrator value |
| int_neg | output | 16 | Negative integrator value |

## Verification
A wrong integrator value shows on `int_pos` or `int_neg` in the clock after the strobe that caused it. Through the threshold comparison, it also moves the trip edge by at least one sample. A dropout counter that is off by one stays hidden until the first large down step. That step then arrives one sample early or late, which makes a 15-unit error on the integrator output right after that strobe. A wrong negative path in single mode shows at once as a nonzero `int_neg`.

// File: rtl/pc_coinc_pkg.sv
package pc_coinc_pkg;
  localparam int NUM_POL = 2;
  typedef enum logic {POL_POS = 1'b0, POL_NEG = 1'b1} pol_e;
  typedef struct packed {
    logic loc;
    logic rem1;
    logic rem2;
  } pulse_set_t;
endpackage

// File: rtl/pc_coinc_logic.sv
module pc_coinc_logic
  import pc_coinc_pkg::*;
(
  input  logic       fault_det,
  input  logic       three_term,
  input  pulse_set_t pulses,
  output logic       coinc
);
  logic far_ok;
  always_comb begin
    // rem2 only counts in three-terminal operation
    far_ok = pulses.rem1 & (pulses.rem2 | ~three_term);
    coinc  = fault_det & pulses.loc & far_ok;
  end
endmodule

// File: rtl/pc_integ_path.sv
module pc_integ_path #(
  parameter int VAL_W = 16,
  parameter int DLY_W = 8,
  parameter int STEP_UP = 10,
  parameter int STEP_DN_S = 5,
  parameter int STEP_DN_L = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             smp_en,
  input  logic             coinc,
  input  logic [VAL_W-1:0] int_max,
  input  logic [DLY_W-1:0] ext_len,
  output logic [VAL_W-1:0] val,
  output logic [VAL_W-1:0] val_nxt
);
  localparam logic [VAL_W:0]   UP_W  = (VAL_W+1)'(STEP_UP);
  localparam logic [VAL_W-1:0] DNS_W = VAL_W'(STEP_DN_S);
  localparam logic [VAL_W-1:0] DNL_W = VAL_W'(STEP_DN_L);
  localparam logic [DLY_W-1:0] CNT_TOP = '1;

  logic [DLY_W-1:0] zero_cnt;
  logic [VAL_W:0]   up_sum;
  logic [VAL_W-1:0] dn_step;
  logic [VAL_W-1:0] calc;

  always_comb begin
    up_sum  = {1'b0, val} + UP_W;
    dn_step = (zero_cnt >= ext_len) ? DNL_W : DNS_W;
    if (coinc)
      calc = (up_sum > {1'b0, int_max}) ? int_max : up_sum[VAL_W-1:0];
    else
      calc = (val < dn_step) ? '0 : val - dn_step;
    val_nxt = en ? calc : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      val      <= '0;
      zero_cnt <= '0;
    end else if (smp_en) begin
      val <= calc;
      if (coinc)
        zero_cnt <= '0;
      else if (zero_cnt != CNT_TOP)
        zero_cnt <= zero_cnt + 1'b1;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!smp_en && en) |=> $stable(val));
  assert_up_step_R3: assert property (@(posedge clk) disable iff (rst)
    (smp_en && en && coinc && (up_sum <= {1'b0, int_max}))
    |=> (val == $past(val) + VAL_W'(STEP_UP)));
  assert_short_dn_R4: assert property (@(posedge clk) disable iff (rst)
    (smp_en && en && !coinc && (zero_cnt < ext_len) && (val >= DNS_W))
    |=> (val == $past(val) - DNS_W));
  assert_long_dn_R5: assert property (@(posedge clk) disable iff (rst)
    (smp_en && en && !coinc && (zero_cnt >= ext_len) && (val >= DNL_W))
    |=> (val == $past(val) - DNL_W));
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (smp_en && en && !coinc) |=> (val <= $past(val)));
  assert_run_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (smp_en && en && coinc) |=> (zero_cnt == '0));
endmodule

// File: rtl/pc_coinc_integ.sv
module pc_coinc_integ
  import pc_coinc_pkg::*;
#(
  parameter int VAL_W = 16,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_en,
  input  logic             dual_mode,
  input  logic             three_term,
  input  logic             fault_det,
  input  logic             loc_pos,
  input  logic             rem1_pos,
  input  logic             rem2_pos,
  input  logic             loc_neg,
  input  logic             rem1_neg,
  input  logic             rem2_neg,
  input  logic [VAL_W-1:0] thresh,
  input  logic [VAL_W-1:0] int_max,
  input  logic [DLY_W-1:0] ext_len,
  output logic             trip,
  output logic [VAL_W-1:0] int_pos,
  output logic [VAL_W-1:0] int_neg
);
  pulse_set_t       pset  [NUM_POL];
  logic             coinc [NUM_POL];
  logic             p_en  [NUM_POL];
  logic [VAL_W-1:0] val   [NUM_POL];
  logic [VAL_W-1:0] nxt   [NUM_POL];

  assign pset[POL_POS] = '{loc: loc_pos, rem1: rem1_pos, rem2: rem2_pos};
  assign pset[POL_NEG] = '{loc: loc_neg, rem1: rem1_neg, rem2: rem2_neg};
  assign p_en[POL_POS] = 1'b1;
  assign p_en[POL_NEG] = dual_mode;

  for (genvar p = 0; p < NUM_POL; p++) begin : g_pol
    pc_coinc_logic u_coinc (
      .fault_det (fault_det),
      .three_term(three_term),
      .pulses    (pset[p]),
      .coinc     (coinc[p])
    );
    pc_integ_path #(.VAL_W(VAL_W), .DLY_W(DLY_W)) u_path (
      .clk    (clk),
      .rst    (rst),
      .en     (p_en[p]),
      .smp_en (smp_en),
      .coinc  (coinc[p]),
      .int_max(int_max),
      .ext_len(ext_len),
      .val    (val[p]),
      .val_nxt(nxt[p])
    );
  end

  assign int_pos = val[POL_POS];
  assign int_neg = val[POL_NEG];

  always_ff @(posedge clk) begin
    if (rst)
      trip <= 1'b0;
    else if (smp_en)
      trip <= (nxt[POL_POS] >= thresh) | (dual_mode & (nxt[POL_NEG] >= thresh));
  end

  assert_trip_cmp_R8: assert property (@(posedge clk) disable iff (rst)
    smp_en |=> (trip == ((int_pos >= $past(thresh)) ||
                         ($past(dual_mode) && (int_neg >= $past(thresh))))));
  assert_trip_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(trip));
  assert_neg_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !dual_mode |=> (int_neg == '0));
  assert_reset_R11: assert property (@(posedge clk)
    rst |=> (!trip && int_pos == '0 && int_neg == '0));
endmodule

// File: tb/pc_coinc_integ_tb_top.sv
module pc_coinc_integ_tb_top;
  logic clk = 1'b0;
  logic rst, smp_en, dual_mode, three_term, fault_det;
  logic loc_pos, rem1_pos, rem2_pos, loc_neg, rem1_neg, rem2_neg;
  logic [15:0] thresh, int_max;
  logic [7:0] ext_len;
  logic trip;
  logic [15:0] int_pos, int_neg;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pc_coinc_integ dut_i (
    .clk(clk), .rst(rst), .smp_en(smp_en), .dual_mode(dual_mode),
    .three_term(three_term), .fault_det(fault_det),
    .loc_pos(loc_pos), .rem1_pos(rem1_pos), .rem2_pos(rem2_pos),
    .loc_neg(loc_neg), .rem1_neg(rem1_neg), .rem2_neg(rem2_neg),
    .thresh(thresh), .int_max(int_max), .ext_len(ext_len),
    .trip(trip), .int_pos(int_pos), .int_neg(int_neg)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_pos(logic f, logic l, logic r1, logic r2);
    fault_det = f; loc_pos = l; rem1_pos = r1; rem2_pos = r2;
  endtask

  task automatic set_neg(logic l, logic r1, logic r2);
    loc_neg = l; rem1_neg = r1; rem2_neg = r2;
  endtask

  // one strobe; results are read at the following falling edge
  task automatic strobe(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) smp_en = 1'b1;
      @(negedge clk) smp_en = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 int_pos", int_pos, 0);
    chk("R11 int_neg", int_neg, 0);
    chk("R11 trip", trip, 0);
  endtask

  task automatic t_two_term();
    do_reset();
    dual_mode = 0; three_term = 0; thresh = 25;
    set_pos(1, 1, 1, 0);
    strobe(2);
    chk("R1 int_pos two-term", int_pos, 20);
    chk("R8 trip below setting", trip, 0);
    strobe();
    chk("R3 up step", int_pos, 30);
    chk("R8 trip at setting", trip, 1);
  endtask

  task automatic t_three_term();
    three_term = 1;
    set_pos(1, 1, 1, 0);
    strobe();
    chk("R2 rem2 low no coinc", int_pos, 25);
    chk("R8 trip at equal", trip, 1);
    set_pos(1, 1, 1, 1);
    strobe();
    chk("R2 full coinc", int_pos, 35);
    three_term = 0;
  endtask

  task automatic t_dropout();
    do_reset();
    dual_mode = 0; three_term = 0; thresh = 1000; ext_len = 3;
    set_pos(1, 1, 1, 1);
    strobe(10);
    chk("R3 built up", int_pos, 100);
    set_pos(1, 0, 1, 1);
    strobe(3);
    chk("R4 short steps", int_pos, 85);
    strobe();
    chk("R5 first long step", int_pos, 65);
    strobe(3);
    chk("R5 long steps", int_pos, 5);
    strobe();
    chk("R5 floor at zero", int_pos, 0);
    set_pos(1, 1, 1, 1);
    strobe();
    chk("R6 coinc after run", int_pos, 10);
    set_pos(0, 1, 1, 1);
    strobe();
    chk("R6 run restarted", int_pos, 5);
    ext_len = 8;
  endtask

  task automatic t_hold();
    do_reset();
    thresh = 5; set_pos(1, 1, 1, 1);
    strobe();
    chk("R7 pre", int_pos, 10);
    chk("R7 trip pre", trip, 1);
    set_pos(0, 0, 0, 0); thresh = 100;
    repeat (6) @(negedge clk);
    chk("R7 held without strobe", int_pos, 10);
    chk("R7 trip held", trip, 1);
  endtask

  task automatic t_saturate();
    do_reset();
    int_max = 35; thresh = 1000; set_pos(1, 1, 1, 1);
    strobe(5);
    chk("R3 clamp at max", int_pos, 35);
    int_max = 16'hFFFF;
  endtask

  task automatic t_single();
    do_reset();
    dual_mode = 0; thresh = 15;
    set_pos(1, 0, 0, 0); set_neg(1, 1, 1);
    strobe(4);
    chk("R9 neg held", int_neg, 0);
    chk("R9 trip from neg ignored", trip, 0);
  endtask

  task automatic t_dual();
    do_reset();
    dual_mode = 1; thresh = 25;
    set_pos(1, 0, 1, 1); set_neg(1, 1, 0);
    strobe(2);
    chk("R10 neg rises", int_neg, 20);
    chk("R10 pos stays", int_pos, 0);
    chk("R8 no trip yet", trip, 0);
    strobe();
    chk("R8 trip from neg", trip, 1);
    set_pos(1, 1, 1, 1); set_neg(0, 1, 1);
    strobe();
    chk("R10 pos independent", int_pos, 10);
    chk("R10 neg short drop", int_neg, 25);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R11 mid reset neg", int_neg, 0);
    chk("R11 mid reset trip", trip, 0);
    dual_mode = 0;
  endtask

  initial begin
    rst = 1; smp_en = 0; dual_mode = 0; three_term = 0;
    set_pos(0, 0, 0, 0); set_neg(0, 0, 0);
    thresh = 16'hFFFF; int_max = 16'hFFFF; ext_len = 8;
    repeat (3) @(negedge clk);
    t_reset();
    t_two_term();
    t_three_term();
    t_dropout();
    t_hold();
    t_saturate();
    t_single();
    t_dual();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule